// File: doc/BRIEF.md
# UART Host Register Block

This block is the host-facing side of a serial port. A host reaches four 32-bit word registers through a plain address bus with single-cycle read and write strobes: a status word, a control word, a receive data word and a transmit data word. The control word is held here and fans out to the serial engines as separate fields: a baud accumulator step, a 7/8-bit data size, a stop-bit count and a parity mode. The block also gathers the events those engines report.

On the receive side, the block keeps one held byte with a not-empty flag. It also keeps sticky parity, framing and overrun flags. These flags clear as a side effect of host reads. On the transmit side, it keeps one held byte and offers it to the transmitter with a valid/ready handshake. The transmit-empty flag stays low until the transmitter signals that the byte has left the line.

Read data is registered. It appears on the data bus the cycle after the read strobe and holds until the next read.

Top module: `uart_regif`

## Requirements
- R1: After a synchronous reset, the control and receive data words read zero, all error flags are zero, `tx_valid` is low, and the status word reads 0x0000_0002 (only transmit-empty set).
- R2: A write to offset 0x4 stores bits 31..16 (baud step), bit 3 (1 = 8-bit data), bit 2 (1 = two stop bits) and bits 1..0 (parity: 00 none, 01 odd, 10 even). Reading it back returns those bits with bits 15..4 as zero, and the `ctl_*` outputs carry the fields from the next cycle.
- R3: A read strobe with address A puts the word at A on `bus_rdata` one cycle later. Reads of offset 0xC (transmit, write-only) and of unmapped offsets return zero.
- R4: A `rx_valid` pulse stores `rx_data` as the held byte and sets status bit 0. In 7-bit mode, bit 7 of the stored byte is forced to zero.
- R5: A read of offset 0x8 returns the held byte in bits 7..0 with zeros above it. In the same edge it clears the held byte and status bit 0, unless a new frame arrives in that cycle.
- R6: A `rx_valid` pulse while status bit 0 is set, and no receive data read is in that cycle, sets the sticky overrun flag (status bit 2). The newer byte replaces the held one.
- R7: A `rx_valid` pulse with `rx_parity_err` sets sticky status bit 4. With `rx_frame_err`, it sets sticky status bit 3.
- R8: A read of offset 0x0 returns the flags as they were and clears bits 4, 3 and 2. If a setting event falls in the same cycle, the set wins.
- R9: A write to offset 0xC while status bit 1 is set loads bits 7..0 (bit 7 zeroed in 7-bit mode), raises `tx_valid` and clears status bit 1. `tx_valid` falls on a cycle with `tx_ready` high. Status bit 1 returns only on a `tx_done` pulse.
- R10: A write to offset 0xC while status bit 1 is clear changes neither `tx_data` nor the handshake.
- R11: Writes to offsets 0x0 and 0x8 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ctl_baud_inc | output | 16 | Baud accumulator step |
| ctl_data8 | output | 1 | 1 = 8-bit data, 0 = 7-bit |
| ctl_stop2 | output | 1 | 1 = two stop bits |
| ctl_parity | output | 2 | Parity mode |
| rx_valid | input | 1 | Receiver finished a frame |
| rx_data | input | DATA_W | Received byte |
| rx_parity_err | input | 1 | Frame had bad parity (with rx_valid) |
| rx_frame_err | input | 1 | Frame had bad stop bit (with rx_valid) |
| tx_valid | output | 1 | Held transmit byte offered |
| tx_data | output | DATA_W | Held transmit byte |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| tx_done | input | 1 | Transmitter finished sending the byte |

## Verification
Every result is due exactly one clock edge after its stimulus, because there is a single register stage everywhere:
- read data lands on the edge that samples the read strobe;
- control fields and the transmit handshake change on the edge that samples the write;
- flags change on the edge that samples `rx_valid` or the clearing read.

The bench drives each strobe for one cycle from a falling edge and samples on the next falling edge, half a cycle after the edge that updates the result. The same-cycle collision of a status read with an error event is driven as one combined strobe. This checks both the returned old value and the flag that survives.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int REG_W = 32;
  localparam int BAUD_W = 16;

  localparam logic [3:0] OFF_STAT = 4'h0;
  localparam logic [3:0] OFF_CTRL = 4'h4;
  localparam logic [3:0] OFF_RXD  = 4'h8;
  localparam logic [3:0] OFF_TXD  = 4'hC;

  localparam int ST_RXNE = 0;
  localparam int ST_TXE  = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_FE   = 3;
  localparam int ST_PE   = 4;
  localparam int ST_W    = 5;

  typedef struct packed {
    logic [BAUD_W-1:0] baud_inc;
    logic              data8;
    logic              stop2;
    logic [1:0]        parity;
  } ctrl_t;
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_pe,
  input  logic              rx_fe,
  input  logic              data8,
  input  logic              rd_data,
  input  logic              rd_stat,
  output logic [DATA_W-1:0] hold_data,
  output logic              rxne,
  output logic              ovr,
  output logic              pe,
  output logic              fe
);
  logic [DATA_W-1:0] in_masked;

  always_comb begin
    in_masked = rx_data;
    if (!data8) in_masked[DATA_W-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      rxne      <= 1'b0;
      ovr       <= 1'b0;
      pe        <= 1'b0;
      fe        <= 1'b0;
    end else begin
      if (rx_valid) begin
        hold_data <= in_masked;
        rxne      <= 1'b1;
      end else if (rd_data) begin
        hold_data <= '0;
        rxne      <= 1'b0;
      end

      if (rx_valid && rxne && !rd_data) ovr <= 1'b1;
      else if (rd_stat)                 ovr <= 1'b0;

      if (rx_valid && rx_pe) pe <= 1'b1;
      else if (rd_stat)      pe <= 1'b0;

      if (rx_valid && rx_fe) fe <= 1'b1;
      else if (rd_stat)      fe <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_txd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              data8,
  input  logic              tx_ready,
  input  logic              tx_done,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              txe
);
  logic busy;
  logic [DATA_W-1:0] wr_masked;

  always_comb begin
    wr_masked = wdata;
    if (!data8) wr_masked[DATA_W-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (wr_txd && !busy) begin
      busy     <= 1'b1;
      tx_valid <= 1'b1;
      tx_data  <= wr_masked;
    end else begin
      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      if (tx_done) begin
        busy     <= 1'b0;
        tx_valid <= 1'b0;
      end
    end
  end

  assign txe = !busy;
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  output logic [BAUD_W-1:0]   ctl_baud_inc,
  output logic                ctl_data8,
  output logic                ctl_stop2,
  output logic [1:0]          ctl_parity,
  input  logic                rx_valid,
  input  logic [DATA_W-1:0]   rx_data,
  input  logic                rx_parity_err,
  input  logic                rx_frame_err,
  output logic                tx_valid,
  output logic [DATA_W-1:0]   tx_data,
  input  logic                tx_ready,
  input  logic                tx_done
);
  localparam int CTRL_LOW_W = 4;

  ctrl_t             ctrl_q;
  logic              sel_stat, sel_ctrl, sel_rxd, sel_txd;
  logic [DATA_W-1:0] hold_data;
  logic              rxne, txe, st_ovr, st_pe, st_fe;
  logic [ST_W-1:0]   status;
  logic [REG_W-1:0]  rd_mux;

  assign sel_stat = (bus_addr == ADDR_W'(OFF_STAT));
  assign sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
  assign sel_rxd  = (bus_addr == ADDR_W'(OFF_RXD));
  assign sel_txd  = (bus_addr == ADDR_W'(OFF_TXD));

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (bus_wr && sel_ctrl)
      ctrl_q <= ctrl_t'({bus_wdata[REG_W-1:REG_W-BAUD_W], bus_wdata[CTRL_LOW_W-1:0]});
  end

  assign ctl_baud_inc = ctrl_q.baud_inc;
  assign ctl_data8    = ctrl_q.data8;
  assign ctl_stop2    = ctrl_q.stop2;
  assign ctl_parity   = ctrl_q.parity;

  uart_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_pe     (rx_parity_err),
    .rx_fe     (rx_frame_err),
    .data8     (ctrl_q.data8),
    .rd_data   (bus_rd && sel_rxd),
    .rd_stat   (bus_rd && sel_stat),
    .hold_data (hold_data),
    .rxne      (rxne),
    .ovr       (st_ovr),
    .pe        (st_pe),
    .fe        (st_fe)
  );

  uart_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .wr_txd   (bus_wr && sel_txd),
    .wdata    (bus_wdata[DATA_W-1:0]),
    .data8    (ctrl_q.data8),
    .tx_ready (tx_ready),
    .tx_done  (tx_done),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .txe      (txe)
  );

  always_comb begin
    status          = '0;
    status[ST_RXNE] = rxne;
    status[ST_TXE]  = txe;
    status[ST_OVR]  = st_ovr;
    status[ST_FE]   = st_fe;
    status[ST_PE]   = st_pe;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_stat)      rd_mux = REG_W'(status);
    else if (sel_ctrl) rd_mux = {ctrl_q.baud_inc, {(REG_W-BAUD_W-CTRL_LOW_W){1'b0}},
                                 ctrl_q.data8, ctrl_q.stop2, ctrl_q.parity};
    else if (sel_rxd)  rd_mux = REG_W'(hold_data);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [31:0]       bus_rdata,
  input logic              rx_valid,
  input logic              rx_parity_err,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic              rxne,
  input logic              txe,
  input logic              st_pe,
  input logic              st_fe,
  input logic              st_ovr
);
  // R4
  rx_sets_rxne_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> rxne);

  // R7
  parity_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_parity_err) |=> st_pe);

  // R8
  stat_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(4'h0) && !rx_valid) |=> (!st_pe && !st_fe && !st_ovr));

  // R3
  txd_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(4'hC)) |=> (bus_rdata == 32'h0));

  // R9
  tx_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(4'hC) && txe) |=> (tx_valid && !txe));

  // R10
  tx_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(4'hC) && !txe) |=> $stable(tx_data));

  // R5
  rxd_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(4'h8) && !rx_valid) |=> !rxne);
endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_addr      (bus_addr),
  .bus_rd        (bus_rd),
  .bus_wr        (bus_wr),
  .bus_rdata     (bus_rdata),
  .rx_valid      (rx_valid),
  .rx_parity_err (rx_parity_err),
  .tx_valid      (tx_valid),
  .tx_data       (tx_data),
  .rxne          (rxne),
  .txe           (txe),
  .st_pe         (st_pe),
  .st_fe         (st_fe),
  .st_ovr        (st_ovr)
);

// File: tb/uart_regif_tb.sv
`timescale 1ns/1ps
module uart_regif_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] ctl_baud_inc;
  logic        ctl_data8, ctl_stop2;
  logic [1:0]  ctl_parity;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_parity_err = 1'b0, rx_frame_err = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0, tx_done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  uart_regif u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_baud_inc(ctl_baud_inc),
    .ctl_data8(ctl_data8), .ctl_stop2(ctl_stop2), .ctl_parity(ctl_parity),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
    .rx_frame_err(rx_frame_err), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_done(tx_done)
  );

  typedef struct packed {
    logic [31:0] wdata;
    logic [31:0] expect_rd;
  } ctrl_vec_t;

  localparam int NVEC = 5;
  localparam ctrl_vec_t VEC [NVEC] = '{
    '{32'hFFFF_FFFF, 32'hFFFF_000F},
    '{32'h1234_5678, 32'h1234_0008},
    '{32'h0097_0005, 32'h0097_0005},
    '{32'h0000_000A, 32'h0000_000A},
    '{32'h004B_0008, 32'h004B_0008}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic pe, input logic fe);
    @(negedge clk);
    rx_data = d; rx_parity_err = pe; rx_frame_err = fe; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_parity_err = 1'b0; rx_frame_err = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(4'h0, rd); chk("R1 status", rd, 32'h2);
    bus_read(4'h4, rd); chk("R1 control", rd, 32'h0);
    bus_read(4'h8, rd); chk("R1 rxdata", rd, 32'h0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);

    // R2 control vectors
    for (int i = 0; i < NVEC; i++) begin
      bus_write(4'h4, VEC[i].wdata);
      chk("R2 baud port", {16'b0, ctl_baud_inc}, {16'b0, VEC[i].expect_rd[31:16]});
      chk("R2 field ports", {28'b0, ctl_data8, ctl_stop2, ctl_parity}, {28'b0, VEC[i].expect_rd[3:0]});
      bus_read(4'h4, rd);
      chk("R2 readback", rd, VEC[i].expect_rd);
    end

    // R3 write-only transmit word reads zero
    bus_read(4'hC, rd); chk("R3 txd read", rd, 32'h0);
    bus_read(4'h2, rd); chk("R3 unmapped read", rd, 32'h0);

    // R4 / R5 receive in 8-bit mode
    rx_frame(8'hC3, 1'b0, 1'b0);
    bus_read(4'h0, rd); chk("R4 rxne set", rd, 32'h3);
    bus_read(4'h8, rd); chk("R5 rx byte", rd, 32'hC3);
    bus_read(4'h0, rd); chk("R5 rxne cleared", rd, 32'h2);
    bus_read(4'h8, rd); chk("R5 byte cleared", rd, 32'h0);

    // R4 7-bit mode masks bit 7
    bus_write(4'h4, 32'h004B_0000);
    rx_frame(8'hC3, 1'b0, 1'b0);
    bus_read(4'h8, rd); chk("R4 seven bit", rd, 32'h43);
    bus_write(4'h4, 32'h004B_0008);

    // R6 overrun, newest byte kept; R8 status read clears it
    rx_frame(8'h11, 1'b0, 1'b0);
    rx_frame(8'h22, 1'b0, 1'b0);
    bus_read(4'h0, rd); chk("R6 overrun", rd, 32'h7);
    bus_read(4'h0, rd); chk("R8 overrun cleared", rd, 32'h3);
    bus_read(4'h8, rd); chk("R6 newest byte", rd, 32'h22);

    // R7 parity and framing flags
    rx_frame(8'h55, 1'b1, 1'b0);
    bus_read(4'h8, rd); chk("R7 byte", rd, 32'h55);
    bus_read(4'h0, rd); chk("R7 parity sticky", rd, 32'h12);
    bus_read(4'h0, rd); chk("R8 parity cleared", rd, 32'h2);
    rx_frame(8'h66, 1'b0, 1'b1);
    bus_read(4'h8, rd);
    bus_read(4'h0, rd); chk("R7 framing sticky", rd, 32'h0A);
    bus_read(4'h0, rd); chk("R8 framing cleared", rd, 32'h2);

    // R8 set wins over clearing read in the same cycle
    @(negedge clk);
    bus_addr = 4'h0; bus_rd = 1'b1;
    rx_data = 8'h3C; rx_parity_err = 1'b1; rx_valid = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; rx_valid = 1'b0; rx_parity_err = 1'b0;
    chk("R8 old value returned", bus_rdata, 32'h2);
    bus_read(4'h0, rd); chk("R8 set wins", rd, 32'h13);
    bus_read(4'h8, rd);
    bus_read(4'h0, rd); chk("R8 after clear", rd, 32'h2);

    // R11 writes to read-only words ignored
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_read(4'h0, rd); chk("R11 status unchanged", rd, 32'h2);
    bus_read(4'h8, rd); chk("R11 rxdata unchanged", rd, 32'h0);

    // R9 transmit handshake
    bus_write(4'hC, 32'h0000_01A5);
    chk("R9 tx_valid", {31'b0, tx_valid}, 32'h1);
    chk("R9 tx_data", {24'b0, tx_data}, 32'hA5);
    bus_read(4'h0, rd); chk("R9 txe low", rd, 32'h0);

    // R10 write while busy ignored
    bus_write(4'hC, 32'h0000_0077);
    chk("R10 tx_data kept", {24'b0, tx_data}, 32'hA5);
    chk("R10 tx_valid kept", {31'b0, tx_valid}, 32'h1);

    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R9 valid drops on ready", {31'b0, tx_valid}, 32'h0);
    bus_read(4'h0, rd); chk("R9 txe still low", rd, 32'h0);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    bus_read(4'h0, rd); chk("R9 txe back", rd, 32'h2);

    // R9 7-bit transmit masks bit 7
    bus_write(4'h4, 32'h004B_0000);
    bus_write(4'hC, 32'h0000_00F0);
    chk("R9 seven bit tx", {24'b0, tx_data}, 32'h70);

    finish_run();
  end
endmodule